// File: doc/BRIEF.md
# LDPC Check-Node Message Update

This unit performs the check-node half of one iteration of a simplified sum-product LDPC decoder, for a single parity-check row. It receives a probability pair (Q0, Q1) for each variable node attached to the row and replaces each pair with one signed difference. For each edge it forms the product of the differences of all the other edges in the row. It then turns that product back into a pair of probabilities (R0, R1) and sends the pair to the variable node.

All values are signed fixed point. A row arrives on one valid/ready transfer, with all edges side by side. The results leave on one valid/ready transfer, and each lane carries the column index it arrived with. Only one row is in flight at a time. The unit takes no new row until the previous result has been taken.

Top module: `ldpc_check_update`

## Requirements
- R1: Every value is 16-bit two's complement with 12 fractional bits, so 1.0 is 4096. Edge k of a bus occupies bits [16k+15:16k], and its column index occupies bits [COLW*k+COLW-1:COLW*k].
- R2: The difference for each edge is Q0 minus Q1, clamped to the range [-32768, 32767].
- R3: A fixed-point product works on magnitudes. A negative operand is negated in two's complement. The product of the magnitudes is shifted right by 12 bits with truncation and limited to 32767. The result is negated when exactly one operand was negative. A product is therefore never -32768.
- R4: For edge k, dR is the product P·S. P is the running product of the differences of edges 0 to k-1, taken in ascending order starting from 4096. S is the running product of the differences of edges DEG-1 down to k+1, taken in descending order starting from 4096. Each step uses the product defined in R3.
- R5: R0 = (4096 + dR) arithmetically shifted right by one, and R1 = (4096 − dR) arithmetically shifted right by one, both rounded toward minus infinity. For every edge, R0 + R1 is therefore 4095 or 4096.
- R6: in_ready is high exactly when no row is held. A row is accepted on a clock edge where in_valid and in_ready are both high. out_valid rises at the second clock edge after acceptance.
- R7: While out_valid is high and out_ready is low, out_valid and all output lanes hold their values. The output is released on the edge where out_valid and out_ready are both high, and in_ready returns in the following cycle.
- R8: The out_col lane for each edge equals the in_col lane of the same edge in the accepted row.
- R9: After reset, out_valid is low and in_ready is high.
- R10: While in_ready is low, in_valid and the input buses have no effect on the outputs of the row in flight or of any later row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input row is present |
| in_ready | output | 1 | Unit can take a row |
| in_q0 | input | DEG*16 | Probability of bit 0, per edge |
| in_q1 | input | DEG*16 | Probability of bit 1, per edge |
| in_col | input | DEG*COLW | Column index, per edge |
| out_valid | output | 1 | Result row is present |
| out_ready | input | 1 | Downstream takes the result |
| out_r0 | output | DEG*16 | Returned probability of bit 0, per edge |
| out_r1 | output | DEG*16 | Returned probability of bit 1, per edge |
| out_col | output | DEG*COLW | Column index, per edge |

## Verification
The latency and column-carry assertions assume two things. First, in_valid, out_ready and the input buses hold known two-state values from the first edge after reset is released. Second, reset is not reasserted while a row is in flight. The bench drives every input only on the falling edge and holds in_valid low through reset. While the unit is busy it deliberately raises in_valid with unrelated data, so that the assertions and the model both see such traffic being refused. Data patterns cover clean probabilities, inverted signs, clamped differences, products that saturate, zero lanes and random pairs. This keeps every input inside the full 16-bit range the product definition allows.

// File: rtl/ldpc_cn_pkg.sv
package ldpc_cn_pkg;

    localparam int W    = 16;
    localparam int FRAC = 12;

    typedef logic signed [W-1:0] fx_t;

    localparam fx_t FX_ONE = fx_t'(1 << FRAC);
    localparam fx_t FX_MAX = fx_t'((1 << (W-1)) - 1);
    localparam fx_t FX_MIN = fx_t'(1 << (W-1));

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_OUT  = 2'd2
    } cn_state_e;

    // clamped difference of two fixed-point values
    function automatic fx_t fx_sub_sat(fx_t a, fx_t b);
        logic signed [W:0] wide;
        wide = $signed({a[W-1], a}) - $signed({b[W-1], b});
        if (wide > $signed({1'b0, FX_MAX}))
            return FX_MAX;
        else if (wide < $signed({1'b1, FX_MIN}))
            return FX_MIN;
        else
            return fx_t'(wide);
    endfunction

    // magnitude of a two's complement operand, one bit wider
    function automatic logic [W:0] fx_mag(fx_t a);
        logic [W:0] ext;
        ext = {a[W-1], a};
        return a[W-1] ? (~ext + 1'b1) : ext;
    endfunction

    // signed product: magnitude multiply, rescale, clamp, then sign
    function automatic fx_t fx_mul(fx_t a, fx_t b);
        localparam logic [2*W+1:0] MAG_LIMIT = (2*W+2)'((1 << (W-1)) - 1);
        logic            neg;
        logic [2*W+1:0]  prod;
        logic [2*W+1:0]  scaled;
        logic [W-1:0]    mag;
        neg    = a[W-1] ^ b[W-1];
        prod   = {{(W+1){1'b0}}, fx_mag(a)} * {{(W+1){1'b0}}, fx_mag(b)};
        scaled = prod >> FRAC;
        mag    = (scaled > MAG_LIMIT) ? MAG_LIMIT[W-1:0] : scaled[W-1:0];
        return neg ? fx_t'(-mag) : fx_t'(mag);
    endfunction

endpackage

// File: rtl/ldpc_cn_diff.sv
module ldpc_cn_diff
    import ldpc_cn_pkg::*;
#(
    parameter int DEG = 6
) (
    input  logic [DEG-1:0][W-1:0] q0_i,
    input  logic [DEG-1:0][W-1:0] q1_i,
    output logic [DEG-1:0][W-1:0] dq_o
);

    // one subtractor per edge of the row
    for (genvar k = 0; k < DEG; k++) begin : g_lane
        assign dq_o[k] = fx_sub_sat(fx_t'(q0_i[k]), fx_t'(q1_i[k]));
    end

endmodule

// File: rtl/ldpc_cn_excl.sv
module ldpc_cn_excl
    import ldpc_cn_pkg::*;
#(
    parameter int DEG = 6
) (
    input  logic [DEG-1:0][W-1:0] dq_i,
    output logic [DEG-1:0][W-1:0] dr_o
);

    // fwd[k]: product of edges 0..k-1 ; bwd[k]: product of edges DEG-1..k
    logic [DEG-1:0][W-1:0] fwd;
    logic [DEG:1][W-1:0]   bwd;

    assign fwd[0]   = FX_ONE;
    assign bwd[DEG] = FX_ONE;

    for (genvar k = 1; k < DEG; k++) begin : g_fwd
        assign fwd[k] = fx_mul(fx_t'(fwd[k-1]), fx_t'(dq_i[k-1]));
    end

    for (genvar k = DEG-1; k >= 1; k--) begin : g_bwd
        assign bwd[k] = fx_mul(fx_t'(dq_i[k]), fx_t'(bwd[k+1]));
    end

    // the edge's own difference never enters its reply
    for (genvar k = 0; k < DEG; k++) begin : g_join
        assign dr_o[k] = fx_mul(fx_t'(fwd[k]), fx_t'(bwd[k+1]));
    end

endmodule

// File: rtl/ldpc_cn_split.sv
module ldpc_cn_split
    import ldpc_cn_pkg::*;
#(
    parameter int DEG = 6
) (
    input  logic [DEG-1:0][W-1:0] dr_i,
    output logic [DEG-1:0][W-1:0] r0_o,
    output logic [DEG-1:0][W-1:0] r1_o
);

    localparam logic signed [W:0] ONE_X = (W+1)'(1 << FRAC);

    // halving by arithmetic right shift, rounding toward minus infinity
    for (genvar k = 0; k < DEG; k++) begin : g_lane
        assign r0_o[k] = W'((ONE_X + $signed({dr_i[k][W-1], dr_i[k]})) >>> 1);
        assign r1_o[k] = W'((ONE_X - $signed({dr_i[k][W-1], dr_i[k]})) >>> 1);
    end

endmodule

// File: rtl/ldpc_check_update.sv
module ldpc_check_update
    import ldpc_cn_pkg::*;
#(
    parameter int DEG  = 6,
    parameter int COLW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DEG*W-1:0]    in_q0,
    input  logic [DEG*W-1:0]    in_q1,
    input  logic [DEG*COLW-1:0] in_col,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DEG*W-1:0]    out_r0,
    output logic [DEG*W-1:0]    out_r1,
    output logic [DEG*COLW-1:0] out_col
);

    typedef logic [DEG-1:0][W-1:0]    lanes_t;
    typedef logic [DEG-1:0][COLW-1:0] cols_t;

    typedef struct packed {
        cn_state_e st;
        lanes_t    dq;
        cols_t     col;
        lanes_t    r0;
        lanes_t    r1;
    } cn_regs_t;

    cn_regs_t s_d, s_q;

    lanes_t q0_w, q1_w, dq_w, dr_w, r0_w, r1_w;
    cols_t  col_w;

    assign q0_w  = lanes_t'(in_q0);
    assign q1_w  = lanes_t'(in_q1);
    assign col_w = cols_t'(in_col);

    // stage 1: per-edge difference straight from the input bus
    ldpc_cn_diff #(.DEG(DEG)) u_diff (
        .q0_i (q0_w),
        .q1_i (q1_w),
        .dq_o (dq_w)
    );

    // stage 2: exclusive products from the captured differences
    ldpc_cn_excl #(.DEG(DEG)) u_excl (
        .dq_i (s_q.dq),
        .dr_o (dr_w)
    );

    ldpc_cn_split #(.DEG(DEG)) u_split (
        .dr_i (dr_w),
        .r0_o (r0_w),
        .r1_o (r1_w)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    s_d.dq  = dq_w;
                    s_d.col = col_w;
                    s_d.st  = ST_CALC;
                end
            end
            ST_CALC: begin
                s_d.r0 = r0_w;
                s_d.r1 = r1_w;
                s_d.st = ST_OUT;
            end
            ST_OUT: begin
                if (out_ready) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready  = (s_q.st == ST_IDLE);
    assign out_valid = (s_q.st == ST_OUT);
    assign out_r0    = s_q.r0;
    assign out_r1    = s_q.r1;
    assign out_col   = s_q.col;

    // ---------------- assertions ----------------

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_ready && rst_n, 2) && $past(rst_n, 1)) |-> out_valid); // R6

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_r0)
                                       && $stable(out_r1) && $stable(out_col))); // R7

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(s_q.dq)); // R10

    AST_COL_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_col == $past(in_col, 2))); // R8

    AST_NO_READY_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid)); // R7

    for (genvar k = 0; k < DEG; k++) begin : g_chk
        AST_PAIR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ((int'($signed(s_q.r0[k])) + int'($signed(s_q.r1[k])) == 4095)
                        || (int'($signed(s_q.r0[k])) + int'($signed(s_q.r1[k])) == 4096))); // R5

        AST_NO_FULL_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.st == ST_CALC) |-> (dr_w[k] != FX_MIN)); // R3
    end

endmodule

// File: tb/ldpc_check_update_test.sv
module ldpc_check_update_test;

    localparam int DEG   = 6;
    localparam int COLW  = 4;
    localparam int W     = 16;
    localparam int NROWS = 300;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [DEG*W-1:0]    in_q0 = '0;
    logic [DEG*W-1:0]    in_q1 = '0;
    logic [DEG*COLW-1:0] in_col = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [DEG*W-1:0]    out_r0;
    logic [DEG*W-1:0]    out_r1;
    logic [DEG*COLW-1:0] out_col;

    ldpc_check_update #(.DEG(DEG), .COLW(COLW)) uut (
        .clk, .rst_n, .in_valid, .in_ready, .in_q0, .in_q1, .in_col,
        .out_valid, .out_ready, .out_r0, .out_r1, .out_col
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int phase = 0;   // 0 empty, 1 computing, 2 result held
    int rows  = 0;
    bit done  = 1'b0;
    int q0[DEG], q1[DEG], cv[DEG];
    int er0[DEG], er1[DEG], ecol[DEG];

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // R3 product: magnitudes, truncating rescale, clamp, sign last
    function automatic int fmul(int a, int b);
        longint p;
        bit neg = (a < 0) != (b < 0);
        p = longint'(a < 0 ? -a : a) * longint'(b < 0 ? -b : b);
        p = p >>> 12;
        if (p > 32767) p = 32767;
        return neg ? -int'(p) : int'(p);
    endfunction

    // expected results for the row on the bus (R2, R4, R5, R8)
    task automatic model_accept();
        int dq[DEG];
        for (int k = 0; k < DEG; k++) dq[k] = sat16(q0[k] - q1[k]);
        for (int k = 0; k < DEG; k++) begin
            int lft = 4096;
            int rgt = 4096;
            int dr;
            for (int j = 0; j < k; j++) lft = fmul(lft, dq[j]);
            for (int j = DEG-1; j > k; j--) rgt = fmul(dq[j], rgt);
            dr = fmul(lft, rgt);
            er0[k]  = (4096 + dr) >>> 1;
            er1[k]  = (4096 - dr) >>> 1;
            ecol[k] = cv[k];
        end
    endtask

    task automatic gen_row(int r);
        for (int k = 0; k < DEG; k++) begin
            cv[k] = int'($urandom_range(0, (1 << COLW) - 1));
            case (r)
                0: begin q0[k] = 4096; q1[k] = 0;    end
                1: begin q0[k] = 0;    q1[k] = 4096; end
                2: begin q0[k] = 32767; q1[k] = -32768; end
                3: begin q0[k] = (k == 2) ? 2048 : 3000; q1[k] = (k == 2) ? 2048 : 1096; end
                4: begin q0[k] = 20000 - 3000 * k; q1[k] = -10000 + 7000 * k; end
                default: begin
                    if (r % 4 == 0) begin
                        q0[k] = int'($urandom_range(0, 65535)) - 32768;
                        q1[k] = int'($urandom_range(0, 65535)) - 32768;
                    end else begin
                        q0[k] = int'($urandom_range(0, 4096));
                        q1[k] = 4096 - q0[k];
                    end
                end
            endcase
        end
    endtask

    task automatic drive_bus();
        for (int k = 0; k < DEG; k++) begin
            in_q0[k*W +: W]       = 16'(q0[k]);
            in_q1[k*W +: W]       = 16'(q1[k]);
            in_col[k*COLW +: COLW] = COLW'(cv[k]);
        end
    endtask

    task automatic compare_now();
        check(in_ready == (phase == 0), "R6 R10 in_ready", int'(in_ready), int'(phase == 0));
        check(out_valid == (phase == 2), "R6 R7 out_valid", int'(out_valid), int'(phase == 2));
        if (phase == 2) begin
            for (int k = 0; k < DEG; k++) begin
                int a0 = int'($signed(out_r0[k*W +: W]));
                int a1 = int'($signed(out_r1[k*W +: W]));
                int ac = int'(out_col[k*COLW +: COLW]);
                check(a0 == er0[k], "R1 R2 R3 R4 R5 r0", a0, er0[k]);
                check(a1 == er1[k], "R1 R2 R3 R4 R5 r1", a1, er1[k]);
                check(ac == ecol[k], "R8 col", ac, ecol[k]);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: state during and right after reset
        check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        forever begin
            @(negedge clk);
            compare_now();
            if (rows >= NROWS && phase == 0) break;
            if (phase == 0) begin
                gen_row(rows);
                in_valid = ($urandom_range(0, 3) != 0);
            end else begin
                gen_row(7);           // junk offered while busy: R10
                in_valid = ($urandom_range(0, 1) != 0);
            end
            out_ready = ($urandom_range(0, 2) != 0);
            drive_bus();
            if (phase == 0) begin
                if (in_valid) begin
                    model_accept();
                    rows++;
                    phase = 1;
                end
            end else if (phase == 1) begin
                phase = 2;
            end else if (out_ready) begin
                phase = 0;
            end
        end
        in_valid = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", rows, NROWS);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule